// File: doc/BRIEF.md
# I2C Master Receiver Status Engine

This block is a software-paced I2C master that reads bytes from a slave. Software sets three control bits (start request, stop request, acknowledge enable) and writes them through a control strobe. The strobe also clears the event flag. The engine then runs one bus step and reports the result as an 8-bit status code. When the step is done it raises the event flag, holds SCL low and waits for the next control write. Software picks the next action from the status code it reads.

The bus side is open drain. The block pulls each line low through an output enable and reads the resolved line level back through a two-stage synchroniser. The bit timing comes from a quarter-bit tick. The tick period is `div_i + 1` system clocks, so SCL is high for two quarters and low for two quarters. A data register serves two purposes: software loads it with the slave address plus the read bit before the address phase, and it presents each received byte. The engine reports lost arbitration when it has released SDA but sees the line low while SCL is high. This check runs during the address bits and during the master's acknowledge bit.

Top module: `i2c_mrx_engine`

## Requirements
- R1: After reset the status is 0xF8, the event flag is clear and neither SCL nor SDA is pulled low.
- R2: A control write with start=1 while idle produces a START condition, then status 0x08 with the flag set.
- R3: A control write with start=0 and stop=0 after status 0x08 or 0x10 shifts out the data register MSB first over eight SCL pulses, then samples a ninth bit. It reports 0x40 if SDA was low (ACK) and 0x48 if SDA was high (NACK).
- R4: A control write with start=0 and stop=0 after 0x40 or 0x50 receives one byte MSB first into the data register. If ack enable was 1 in that write, the engine drives SDA low on the ninth bit and reports 0x50. If it was 0, the engine leaves SDA released and reports 0x58.
- R5: While the flag is set after any status other than 0x38, SCL is pulled low, and the status does not change until the next control write.
- R6: Whenever the flag is clear, the status reads 0xF8.
- R7: A control write with start=1 and stop=0 at a held event produces a repeated START, then status 0x10.
- R8: A control write with start=0 and stop=1 at a held event produces a STOP, then returns to idle: status 0xF8, flag clear, both lines released.
- R9: A control write with start=1 and stop=1 at a held event produces a STOP, then a fresh START once the bus is free, then status 0x08.
- R10: If the engine releases SDA during an address bit and samples it low while SCL is high, it releases both lines at once and reports 0x38.
- R11: If the engine releases SDA to send NACK and samples it low while SCL is high, it releases both lines and reports 0x38.
- R12: After 0x38, a control write with start=0 returns the engine to idle with status 0xF8. A write with start=1 waits until both lines are high, then sends a START and reports 0x08.
- R13: During a transfer, each SCL high phase lasts exactly 2*(div_i+1) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Quarter-bit tick period minus one (must be at least 3) |
| ctl_we_i | input | 1 | Control write strobe; clears the event flag |
| sta_i | input | 1 | Start request bit of the control write |
| sto_i | input | 1 | Stop request bit of the control write |
| aa_i | input | 1 | Acknowledge enable for the next received byte |
| dat_we_i | input | 1 | Data register write strobe (accepted while idle or held) |
| dat_i | input | 8 | Data register write value |
| dat_o | output | 8 | Data register: last received byte or loaded address |
| status_o | output | 8 | Event status code |
| int_o | output | 1 | Event flag |
| scl_i | input | 1 | Resolved SCL line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Resolved SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach from the ports is arbitration loss during the master's acknowledge bit. This needs a second driver to hold SDA low in the single bit where the engine releases SDA to send NACK. The bench slave model tracks the bit count on the resolved bus. When armed, it keeps SDA low into that ninth bit instead of releasing it. The bench then releases the line, and the resulting STOP edge returns the model to idle. The address-phase loss is forced differently: a jam line is held low from the 0x08 hold so that the first released address bit is read back as zero.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RSTART   = 8'h10;
  localparam logic [7:0] ST_ARB      = 8'h38;
  localparam logic [7:0] ST_SLA_ACK  = 8'h40;
  localparam logic [7:0] ST_SLA_NACK = 8'h48;
  localparam logic [7:0] ST_RX_ACK   = 8'h50;
  localparam logic [7:0] ST_RX_NACK  = 8'h58;
  localparam logic [7:0] ST_IDLE     = 8'hF8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_AACK, PH_DATA,
    PH_DACK, PH_HOLD, PH_STOP, PH_WAIT
  } phase_e;
endpackage

// File: rtl/i2c_mrx_tick.sv
module i2c_mrx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R13
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q && div_i != '0 |=> !tick_q);
endmodule

// File: rtl/i2c_mrx_sync.sv
module i2c_mrx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) ff_q[i] <= '1;
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_mrx_fsm.sv
module i2c_mrx_fsm
  import i2c_mrx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       ctl_we_i,
  input  logic       sta_i,
  input  logic       sto_i,
  input  logic       aa_i,
  input  logic       dat_we_i,
  input  logic [7:0] dat_i,
  output logic [7:0] dat_o,
  output logic [7:0] status_o,
  output logic       int_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  phase_e     ph_q;
  logic [1:0] q_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q, dat_q, status_q;
  logic       int_q, aa_q, rep_q, restart_q, ack_q, scl_oe_q, sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      q_q       <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      dat_q     <= '0;
      status_q  <= ST_IDLE;
      int_q     <= 1'b0;
      aa_q      <= 1'b0;
      rep_q     <= 1'b0;
      restart_q <= 1'b0;
      ack_q     <= 1'b0;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else begin
      if (dat_we_i && (ph_q == PH_IDLE || ph_q == PH_HOLD)) dat_q <= dat_i;
      case (ph_q)
        PH_IDLE: if (ctl_we_i && sta_i) begin
          ph_q  <= PH_START;
          q_q   <= '0;
          rep_q <= 1'b0;
          aa_q  <= aa_i;
        end
        PH_HOLD: if (ctl_we_i) begin
          int_q    <= 1'b0;
          status_q <= ST_IDLE;
          aa_q     <= aa_i;
          q_q      <= '0;
          bit_q    <= '0;
          if (status_q == ST_ARB) begin
            ph_q <= sta_i ? PH_WAIT : PH_IDLE;
          end else if (sto_i) begin
            ph_q      <= PH_STOP;
            restart_q <= sta_i;
          end else if (sta_i) begin
            ph_q  <= PH_START;
            rep_q <= 1'b1;
          end else if (status_q == ST_START || status_q == ST_RSTART) begin
            ph_q <= PH_ADDR;
            sh_q <= dat_q;
          end else begin
            ph_q <= PH_DATA;
          end
        end
        PH_WAIT: if (tick_i && scl_i && sda_i) begin
          ph_q  <= PH_START;
          q_q   <= '0;
          rep_q <= 1'b0;
        end
        default: if (tick_i) begin
          q_q <= q_q + 2'd1;
          case (ph_q)
            PH_START: case (q_q)
              2'd0: sda_oe_q <= 1'b0;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: sda_oe_q <= 1'b1;   // SDA falls, SCL high
              default: begin
                scl_oe_q <= 1'b1;
                ph_q     <= PH_HOLD;
                int_q    <= 1'b1;
                status_q <= rep_q ? ST_RSTART : ST_START;
              end
            endcase
            PH_ADDR: case (q_q)
              2'd0: sda_oe_q <= ~sh_q[7];
              2'd1: scl_oe_q <= 1'b0;
              2'd2: if (!sda_oe_q && !sda_i) begin
                scl_oe_q <= 1'b0;
                sda_oe_q <= 1'b0;
                ph_q     <= PH_HOLD;
                int_q    <= 1'b1;
                status_q <= ST_ARB;
              end
              default: begin
                scl_oe_q <= 1'b1;
                sh_q     <= {sh_q[6:0], 1'b0};
                bit_q    <= bit_q + 3'd1;
                if (bit_q == 3'd7) ph_q <= PH_AACK;
              end
            endcase
            PH_AACK: case (q_q)
              2'd0: sda_oe_q <= 1'b0;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: ack_q    <= ~sda_i;
              default: begin
                scl_oe_q <= 1'b1;
                ph_q     <= PH_HOLD;
                int_q    <= 1'b1;
                status_q <= ack_q ? ST_SLA_ACK : ST_SLA_NACK;
              end
            endcase
            PH_DATA: case (q_q)
              2'd0: sda_oe_q <= 1'b0;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: sh_q     <= {sh_q[6:0], sda_i};
              default: begin
                scl_oe_q <= 1'b1;
                bit_q    <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                  ph_q  <= PH_DACK;
                  dat_q <= sh_q;
                end
              end
            endcase
            PH_DACK: case (q_q)
              2'd0: sda_oe_q <= aa_q;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: if (!aa_q && !sda_i) begin
                scl_oe_q <= 1'b0;
                sda_oe_q <= 1'b0;
                ph_q     <= PH_HOLD;
                int_q    <= 1'b1;
                status_q <= ST_ARB;
              end
              default: begin
                scl_oe_q <= 1'b1;
                ph_q     <= PH_HOLD;
                int_q    <= 1'b1;
                status_q <= aa_q ? ST_RX_ACK : ST_RX_NACK;
              end
            endcase
            PH_STOP: case (q_q)
              2'd0: sda_oe_q <= 1'b1;
              2'd1: scl_oe_q <= 1'b0;
              2'd2: sda_oe_q <= 1'b0;   // SDA rises, SCL high
              default: ph_q <= restart_q ? PH_WAIT : PH_IDLE;
            endcase
            default: ;
          endcase
        end
      endcase
    end
  end

  assign dat_o    = dat_q;
  assign status_o = status_q;
  assign int_o    = int_q;
  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;

  // R5
  hold_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q && status_q != ST_ARB |-> scl_oe_q);
  // R5
  status_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q && !ctl_we_i |=> $stable(status_q));
  // R6
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_q |-> status_q == ST_IDLE);
  // R10
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q && status_q == ST_ARB |-> !scl_oe_q && !sda_oe_q);
endmodule

// File: rtl/i2c_mrx_engine.sv
module i2c_mrx_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ctl_we_i,
  input  logic             sta_i,
  input  logic             sto_i,
  input  logic             aa_i,
  input  logic             dat_we_i,
  input  logic [7:0]       dat_i,
  output logic [7:0]       dat_o,
  output logic [7:0]       status_o,
  output logic             int_o,
  input  logic             scl_i,
  output logic             scl_oe_o,
  input  logic             sda_i,
  output logic             sda_oe_o
);
  logic       tick;
  logic [1:0] line_s;

  i2c_mrx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_i),
    .tick_o(tick)
  );

  i2c_mrx_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  i2c_mrx_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .scl_i   (line_s[1]),
    .sda_i   (line_s[0]),
    .ctl_we_i(ctl_we_i),
    .sta_i   (sta_i),
    .sto_i   (sto_i),
    .aa_i    (aa_i),
    .dat_we_i(dat_we_i),
    .dat_i   (dat_i),
    .dat_o   (dat_o),
    .status_o(status_o),
    .int_o   (int_o),
    .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o)
  );
endmodule

// File: tb/tb_i2c_mrx_engine.sv
module tb_i2c_mrx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int LIMIT      = 100000;
  localparam logic [6:0] SLV_ADDR = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, sta = 0, sto = 0, aa = 0, dat_we = 0;
  logic [7:0] dat_w = '0;
  logic [7:0] dat_o, status_o;
  logic int_o, scl_oe, sda_oe;
  logic sl_low = 0, jam = 0, jam_ack = 0;
  wire scl_bus = !scl_oe;
  wire sda_bus = !sda_oe && !sl_low && !jam;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mrx_engine #(.DIV_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(8'(DIV)),
    .ctl_we_i(ctl_we), .sta_i(sta), .sto_i(sto), .aa_i(aa),
    .dat_we_i(dat_we), .dat_i(dat_w), .dat_o(dat_o),
    .status_o(status_o), .int_o(int_o),
    .scl_i(scl_bus), .scl_oe_o(scl_oe), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] txb(input int k);
    return 8'h3C + 8'(k * 37);
  endfunction

  // slave transmitter model
  localparam int SP_IDLE = 0, SP_ADDR = 1, SP_AACK = 2, SP_DATA = 3, SP_MACK = 4;
  int sph = SP_IDLE, sb = 0, byte_k = 0;
  logic [7:0] addr_sh = '0;
  logic macked = 0;

  always @(negedge sda_bus) if (scl_bus) begin sph = SP_ADDR; sb = 0; end
  always @(posedge sda_bus) if (scl_bus) sph = SP_IDLE;
  always @(posedge scl_bus) begin
    case (sph)
      SP_ADDR: begin addr_sh = {addr_sh[6:0], sda_bus}; sb++; end
      SP_DATA: sb++;
      SP_MACK: macked = !sda_bus;
      default: ;
    endcase
  end
  always @(negedge scl_bus) begin
    case (sph)
      SP_ADDR: if (sb == 8) begin
        if (addr_sh[7:1] == SLV_ADDR && addr_sh[0]) begin
          sl_low = 1; sph = SP_AACK; byte_k = 0;
        end else sph = SP_IDLE;
      end
      SP_AACK: begin sph = SP_DATA; sb = 0; sl_low = !txb(byte_k)[7]; end
      SP_DATA: if (sb < 8) sl_low = !txb(byte_k)[7-sb];
               else begin sl_low = jam_ack; sph = SP_MACK; end
      SP_MACK: if (macked) begin
        byte_k++; sph = SP_DATA; sb = 0; sl_low = !txb(byte_k)[7];
      end else begin sl_low = 0; sph = SP_IDLE; end
      default: ;
    endcase
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_st_q[$];
  logic [7:0] exp_d_q[$];
  logic       exp_c_q[$];
  string      exp_r_q[$];
  logic prev_int = 0;
  int hi_cnt = 0, last_hi = 0;

  always @(negedge clk) begin
    if (!scl_oe) hi_cnt++;
    else begin
      if (hi_cnt != 0) last_hi = hi_cnt;
      hi_cnt = 0;
    end
    if (rst_n && int_o && !prev_int) begin
      if (exp_st_q.size() == 0) check(1'b0, "R5", "unexpected event", status_o, 8'h00);
      else begin
        logic [7:0] st, d;
        logic c;
        string r;
        st = exp_st_q.pop_front(); d = exp_d_q.pop_front();
        c = exp_c_q.pop_front();   r = exp_r_q.pop_front();
        check(status_o == st, r, "status", status_o, st);
        if (c) check(dat_o == d, r, "data", dat_o, d);
        if (st == 8'h38)
          check(!scl_oe && !sda_oe, r, "lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        else
          check(scl_oe, "R5", "scl held", {7'd0, scl_oe}, 8'h01);
        if (st == 8'h50)
          check(last_hi == 2*(DIV+1), "R13", "scl high cycles", 8'(last_hi), 8'(2*(DIV+1)));
      end
    end
    prev_int = int_o;
  end

  task automatic ctl_write(input logic s, input logic p, input logic a);
    @(negedge clk); ctl_we = 1; sta = s; sto = p; aa = a;
    @(negedge clk); ctl_we = 0; sta = 0; sto = 0; aa = 0;
    check(!int_o && status_o == 8'hF8, "R6", "flag clear code", status_o, 8'hF8);
  endtask

  task automatic step(input logic s, input logic p, input logic a, input logic [7:0] st,
                      input logic c, input logic [7:0] d, input string r);
    exp_st_q.push_back(st); exp_d_q.push_back(d); exp_c_q.push_back(c); exp_r_q.push_back(r);
    ctl_write(s, p, a);
    while (!int_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle_step(input logic s, input logic p, input string r);
    ctl_write(s, p, 1'b0);
    repeat (40 * (DIV + 1)) @(negedge clk);
    check(!int_o && status_o == 8'hF8 && !scl_oe && !sda_oe, r, "idle",
          status_o, 8'hF8);
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); dat_we = 1; dat_w = b;
    @(negedge clk); dat_we = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status_o == 8'hF8 && !int_o && !scl_oe && !sda_oe, "R1", "reset", status_o, 8'hF8);

    // read two bytes, repeated start, read one, stop
    step(1, 0, 0, 8'h08, 0, 0, "R2");
    load({SLV_ADDR, 1'b1});
    step(0, 0, 0, 8'h40, 0, 0, "R3");
    step(0, 0, 1, 8'h50, 1, txb(0), "R4");
    step(0, 0, 0, 8'h58, 1, txb(1), "R4");
    step(1, 0, 0, 8'h10, 0, 0, "R7");
    load({SLV_ADDR, 1'b1});
    step(0, 0, 0, 8'h40, 0, 0, "R3");
    step(0, 0, 0, 8'h58, 1, txb(0), "R4");
    idle_step(0, 1, "R8");

    // wrong address, stop then start
    step(1, 0, 0, 8'h08, 0, 0, "R2");
    load(8'hB1);
    step(0, 0, 0, 8'h48, 0, 0, "R3");
    step(1, 1, 0, 8'h08, 0, 0, "R9");
    load({SLV_ADDR, 1'b1});
    step(0, 0, 0, 8'h40, 0, 0, "R3");
    step(0, 0, 1, 8'h50, 1, txb(0), "R4");
    step(0, 0, 0, 8'h58, 1, txb(1), "R4");
    idle_step(0, 1, "R8");

    // address-phase loss, back to idle
    step(1, 0, 0, 8'h08, 0, 0, "R2");
    jam = 1;
    load({SLV_ADDR, 1'b1});
    step(0, 0, 0, 8'h38, 0, 0, "R10");
    jam = 0;
    idle_step(0, 0, "R12");

    // address-phase loss, start again when free
    step(1, 0, 0, 8'h08, 0, 0, "R2");
    jam = 1;
    load({SLV_ADDR, 1'b1});
    step(0, 0, 0, 8'h38, 0, 0, "R10");
    jam = 0;
    step(1, 0, 0, 8'h08, 0, 0, "R12");
    idle_step(0, 1, "R8");

    // ack-phase loss
    step(1, 0, 0, 8'h08, 0, 0, "R2");
    load({SLV_ADDR, 1'b1});
    step(0, 0, 0, 8'h40, 0, 0, "R3");
    jam_ack = 1;
    step(0, 0, 0, 8'h38, 0, 0, "R11");
    jam_ack = 0; sl_low = 0; sph = SP_IDLE;
    idle_step(0, 0, "R12");

    check(exp_st_q.size() == 0, "R5", "pending events", 8'(exp_st_q.size()), 8'h00);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule